// File: doc/BRIEF.md
# Flash Completion Polling Controller

This block sits on the host side of a parallel NOR-style flash bus. It takes a single request, either a word program or a sector erase, and drives the unlock-and-command write sequence onto the bus. It then reads the device status until the embedded operation has ended. When the outcome is final, it reports success or failure.

Two completion tests are available and are chosen per request.

- **Data polling** watches status bit 7. During a program that bit reads as the complement of the data being written, and during an erase it reads as zero. The bit takes its final value once the device has finished.
- **Toggle checking** compares status bit 6 across two consecutive reads. It treats a stable bit as the end of the operation.

Either way, the controller does not trust the read on which completion is first seen. It takes a fixed number of extra reads and compares only the last one against the whole expected word. An unchanged word after a program therefore shows up as a failure, which is what a write to a protected sector produces.

A per-request limit on the number of status reads turns a device that never completes into a failure.

Top module: `flash_poll_top`

## Requirements
- R1: A program request produces exactly four write-enable pulses. Their (address, data) pairs are, in order: (0x555, 0xAA), (0x2AA, 0x55), (0x555, 0xA0), and finally (request address, request data).
- R2: An erase request produces exactly six write-enable pulses. Their (address, data) pairs are, in order: (0x555, 0xAA), (0x2AA, 0x55), (0x555, 0x80), (0x555, 0xAA), (0x2AA, 0x55), and finally (request address, 0x30).
- R3: No read starts before the last write pulse of the sequence has ended. Every status or confirm read is taken at the request address, which for an erase is the sector being erased.
- R4: Each read is a distinct output-enable low pulse lasting one clock, with at least one clock of output-enable high between reads. Write-enable and output-enable are never low together.
- R5: In data-polling mode (toggle select = 0), the search ends on the first read whose bit 7 matches the target. The target is request-data bit 7 for a program and 1 for an erase.
- R6: In toggle mode (toggle select = 1), the search ends on the first read whose bit 6 equals bit 6 of the read just before it. The first read of a search can never end it.
- R7: Once the search ends, exactly CONFIRM_READS further reads are taken. Only the last of them is compared with the full expected word, which is the request data for a program and all ones for an erase. A match gives pass and a mismatch gives fail.
- R8: If the search has taken max(timeoutLimit, 1) reads without ending, the request fails at once and no confirm reads are taken.
- R9: The done output is high for exactly one clock per request. In that clock exactly one of pass and fail is high; both are low in every other clock. The controller then accepts a new request.
- R10: While reset is asserted, write-enable and output-enable are high (inactive) and done, pass and fail are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start a request; accepted only while idle |
| reqErase | input | 1 | 1 = sector erase, 0 = word program |
| reqToggle | input | 1 | 1 = bit-6 toggle checking, 0 = bit-7 data polling |
| reqAddr | input | ADDR_W | Target word / sector address |
| reqData | input | DATA_W | Data to program (ignored for erase) |
| timeoutLimit | input | TIMEOUT_W | Maximum number of search reads (0 acts as 1) |
| flAddr | output | ADDR_W | Flash address bus |
| flDout | output | DATA_W | Flash write data bus |
| flDin | input | DATA_W | Flash read data bus |
| flWeN | output | 1 | Flash write enable, active low |
| flOeN | output | 1 | Flash output enable, active low |
| done | output | 1 | One-clock completion strobe |
| pass | output | 1 | Operation succeeded (valid with done) |
| fail | output | 1 | Operation failed or timed out (valid with done) |

## Verification
The bench builds the block with an 8-bit data bus, a 12-bit address and a 6-bit timeout field, so limits of 0, 1, 4 and 5 reads are reached within a few dozen cycles. It uses two confirm reads. With that setting, an off-by-one in the confirm count changes the total number of output-enable pulses. Evaluating the transitional read, in which only bit 7 is already final, turns a passing program into a fail. The modelled device keeps toggling bit 6 through that transitional read, so toggle detection is exercised both where the final word happens to continue the toggle pattern and where it breaks it.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WLO,
    ST_WHI,
    ST_RLO,
    ST_RHI,
    ST_FIN
  } pollState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latch;
    logic wrNext;
    logic capture;
    logic confirming;
    logic writing;
  } pollCtrl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic wrLast;
    logic detect;
    logic timeout;
    logic confLast;
    logic wordMatch;
  } pollStat_t;

  localparam int PROG_WRITES  = 4;
  localparam int ERASE_WRITES = 6;
  localparam int STATUS_BIT   = 7;
  localparam int TOGGLE_BIT   = 6;

  localparam logic [11:0] UNLOCK_ADDR_A = 12'h555;
  localparam logic [11:0] UNLOCK_ADDR_B = 12'h2AA;
  localparam logic [7:0]  UNLOCK_DATA_A = 8'hAA;
  localparam logic [7:0]  UNLOCK_DATA_B = 8'h55;
  localparam logic [7:0]  CMD_PROGRAM   = 8'hA0;
  localparam logic [7:0]  CMD_ERASE_PRE = 8'h80;
  localparam logic [7:0]  CMD_SECTOR    = 8'h30;

endpackage

// File: rtl/flash_poll_dp.sv
module flash_poll_dp
  import flash_poll_pkg::*;
#(
  parameter int ADDR_W        = 12,
  parameter int DATA_W        = 8,
  parameter int TIMEOUT_W     = 16,
  parameter int CONFIRM_READS = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pollCtrl_t            ctrl,
  input  logic                 reqErase,
  input  logic                 reqToggle,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [DATA_W-1:0]    reqData,
  input  logic [TIMEOUT_W-1:0] timeoutLimit,
  input  logic [DATA_W-1:0]    flDin,
  output logic [ADDR_W-1:0]    flAddr,
  output logic [DATA_W-1:0]    flDout,
  output pollStat_t            stat
);

  localparam int IDX_W  = 3;
  localparam int CONF_W = $clog2(CONFIRM_READS + 1);

  logic                 eraseQ, toggleQ;
  logic [ADDR_W-1:0]    addrQ;
  logic [DATA_W-1:0]    dataQ;
  logic [TIMEOUT_W-1:0] limitQ, searchCnt, effLimit;
  logic [CONF_W-1:0]    confCnt;
  logic [IDX_W-1:0]     wrIdx;
  logic [DATA_W-1:0]    rdCur, rdPrev;
  logic [ADDR_W-1:0]    seqAddr;
  logic [DATA_W-1:0]    seqData, expWord;
  logic                 target7;

  // command sequence generator
  always_comb begin
    seqAddr = ADDR_W'(UNLOCK_ADDR_A);
    seqData = DATA_W'(UNLOCK_DATA_A);
    case (wrIdx)
      3'd0: begin seqAddr = ADDR_W'(UNLOCK_ADDR_A); seqData = DATA_W'(UNLOCK_DATA_A); end
      3'd1: begin seqAddr = ADDR_W'(UNLOCK_ADDR_B); seqData = DATA_W'(UNLOCK_DATA_B); end
      3'd2: begin
        seqAddr = ADDR_W'(UNLOCK_ADDR_A);
        seqData = eraseQ ? DATA_W'(CMD_ERASE_PRE) : DATA_W'(CMD_PROGRAM);
      end
      3'd3: begin
        seqAddr = eraseQ ? ADDR_W'(UNLOCK_ADDR_A) : addrQ;
        seqData = eraseQ ? DATA_W'(UNLOCK_DATA_A) : dataQ;
      end
      3'd4: begin seqAddr = ADDR_W'(UNLOCK_ADDR_B); seqData = DATA_W'(UNLOCK_DATA_B); end
      3'd5: begin seqAddr = addrQ; seqData = DATA_W'(CMD_SECTOR); end
      default: ;
    endcase
  end

  assign flAddr   = ctrl.writing ? seqAddr : addrQ;
  assign flDout   = seqData;
  assign effLimit = (limitQ == '0) ? TIMEOUT_W'(1) : limitQ;
  assign target7  = eraseQ ? 1'b1 : dataQ[STATUS_BIT];
  assign expWord  = eraseQ ? '1 : dataQ;

  always_comb begin
    stat.wrLast    = (wrIdx == IDX_W'(eraseQ ? ERASE_WRITES - 1 : PROG_WRITES - 1));
    stat.detect    = toggleQ ? ((searchCnt >= TIMEOUT_W'(2)) &&
                                (rdCur[TOGGLE_BIT] == rdPrev[TOGGLE_BIT]))
                             : (rdCur[STATUS_BIT] == target7);
    stat.timeout   = (searchCnt >= effLimit);
    stat.confLast  = (confCnt == CONF_W'(CONFIRM_READS));
    stat.wordMatch = (rdCur == expWord);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eraseQ    <= 1'b0;
      toggleQ   <= 1'b0;
      addrQ     <= '0;
      dataQ     <= '0;
      limitQ    <= '0;
      wrIdx     <= '0;
      searchCnt <= '0;
      confCnt   <= '0;
      rdCur     <= '0;
      rdPrev    <= '0;
    end else begin
      if (ctrl.latch) begin
        eraseQ    <= reqErase;
        toggleQ   <= reqToggle;
        addrQ     <= reqAddr;
        dataQ     <= reqData;
        limitQ    <= timeoutLimit;
        wrIdx     <= '0;
        searchCnt <= '0;
        confCnt   <= '0;
      end
      if (ctrl.wrNext) wrIdx <= wrIdx + IDX_W'(1);
      if (ctrl.capture) begin
        rdCur  <= flDin;
        rdPrev <= rdCur;
        if (ctrl.confirming) confCnt <= confCnt + CONF_W'(1);
        else                 searchCnt <= searchCnt + TIMEOUT_W'(1);
      end
    end
  end

  // R8
  search_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    searchCnt <= effLimit);
  // R7
  confirm_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    confCnt <= CONF_W'(CONFIRM_READS));
  // R2
  wr_index_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrIdx <= IDX_W'(ERASE_WRITES - 1));

endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
  import flash_poll_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  pollStat_t stat,
  output pollCtrl_t ctrl,
  output logic      flWeN,
  output logic      flOeN,
  output logic      done,
  output logic      pass,
  output logic      fail
);

  pollState_e state;
  logic       confirmingQ, resPassQ;

  always_comb begin
    ctrl.latch      = (state == ST_IDLE) && reqValid;
    ctrl.wrNext     = (state == ST_WHI) && !stat.wrLast;
    ctrl.capture    = (state == ST_RLO);
    ctrl.confirming = confirmingQ;
    ctrl.writing    = (state == ST_WLO) || (state == ST_WHI);
  end

  assign flWeN = (state != ST_WLO);
  assign flOeN = (state != ST_RLO);
  assign done  = (state == ST_FIN);
  assign pass  = done && resPassQ;
  assign fail  = done && !resPassQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      confirmingQ <= 1'b0;
      resPassQ    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (reqValid) begin
          state       <= ST_WLO;
          confirmingQ <= 1'b0;
        end
        ST_WLO:  state <= ST_WHI;
        ST_WHI:  state <= stat.wrLast ? ST_RLO : ST_WLO;
        ST_RLO:  state <= ST_RHI;
        ST_RHI: begin
          if (confirmingQ) begin
            if (stat.confLast) begin
              resPassQ <= stat.wordMatch;
              state    <= ST_FIN;
            end else begin
              state <= ST_RLO;
            end
          end else if (stat.detect) begin
            confirmingQ <= 1'b1;
            state       <= ST_RLO;
          end else if (stat.timeout) begin
            resPassQ <= 1'b0;
            state    <= ST_FIN;
          end else begin
            state <= ST_RLO;
          end
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4
  no_we_oe_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!flWeN && !flOeN));
  // R4
  oe_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !flOeN |=> flOeN);
  // R9
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R9
  result_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pass || fail) |-> (done && (pass ^ fail)));

endmodule

// File: rtl/flash_poll_top.sv
module flash_poll_top
  import flash_poll_pkg::*;
#(
  parameter int ADDR_W        = 12,
  parameter int DATA_W        = 8,
  parameter int TIMEOUT_W     = 16,
  parameter int CONFIRM_READS = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqErase,
  input  logic                 reqToggle,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [DATA_W-1:0]    reqData,
  input  logic [TIMEOUT_W-1:0] timeoutLimit,
  output logic [ADDR_W-1:0]    flAddr,
  output logic [DATA_W-1:0]    flDout,
  input  logic [DATA_W-1:0]    flDin,
  output logic                 flWeN,
  output logic                 flOeN,
  output logic                 done,
  output logic                 pass,
  output logic                 fail
);

  pollCtrl_t ctrl;
  pollStat_t stat;

  flash_poll_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .stat(stat), .ctrl(ctrl),
    .flWeN(flWeN), .flOeN(flOeN), .done(done), .pass(pass), .fail(fail)
  );

  flash_poll_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIMEOUT_W(TIMEOUT_W),
    .CONFIRM_READS(CONFIRM_READS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .reqErase(reqErase),
    .reqToggle(reqToggle), .reqAddr(reqAddr), .reqData(reqData),
    .timeoutLimit(timeoutLimit), .flDin(flDin), .flAddr(flAddr),
    .flDout(flDout), .stat(stat)
  );

  // R3
  poll_addr_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!flOeN && $past(!flOeN, 2)) |-> (flAddr == $past(flAddr, 2)));

endmodule

// File: tb/tb_flash_poll_top.sv
module tb_flash_poll_top;

  localparam int AW = 12, DW = 8, TW = 6, CONF = 2;

  typedef struct packed {
    logic       erase;
    logic       tog;
    logic [7:0] exp;
    logic [7:0] busy;
    logic [7:0] fin;
    logic [5:0] lim;
    logic [11:0] addr;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 8'h5A, 8'd3,  8'h5A, 6'd20, 12'h123},
    '{1'b0, 1'b1, 8'hC3, 8'd4,  8'hC3, 6'd20, 12'h456},
    '{1'b1, 1'b0, 8'h00, 8'd5,  8'hFF, 6'd20, 12'h7A0},
    '{1'b1, 1'b1, 8'h00, 8'd2,  8'hFF, 6'd20, 12'h3F0},
    '{1'b0, 1'b1, 8'hA5, 8'd1,  8'h00, 6'd20, 12'h0F1},
    '{1'b0, 1'b0, 8'h3C, 8'd10, 8'h3C, 6'd5,  12'h222},
    '{1'b0, 1'b0, 8'h80, 8'd2,  8'h81, 6'd20, 12'h333},
    '{1'b0, 1'b0, 8'h11, 8'd0,  8'h11, 6'd1,  12'h444},
    '{1'b1, 1'b1, 8'h00, 8'd8,  8'hFF, 6'd4,  12'h555},
    '{1'b1, 1'b0, 8'h00, 8'd3,  8'hF7, 6'd20, 12'h666},
    '{1'b0, 1'b0, 8'h66, 8'd5,  8'h66, 6'd0,  12'h777},
    '{1'b0, 1'b1, 8'h0F, 8'd6,  8'h0F, 6'd30, 12'hFFF}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqErase = 1'b0, reqToggle = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqData = '0;
  logic [TW-1:0] timeoutLimit = '0;
  logic [AW-1:0] flAddr;
  logic [DW-1:0] flDout, flDin;
  logic flWeN, flOeN, done, pass, fail;

  always #5 clk = ~clk;

  flash_poll_top #(.ADDR_W(AW), .DATA_W(DW), .TIMEOUT_W(TW), .CONFIRM_READS(CONF)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqErase(reqErase),
    .reqToggle(reqToggle), .reqAddr(reqAddr), .reqData(reqData),
    .timeoutLimit(timeoutLimit), .flAddr(flAddr), .flDout(flDout), .flDin(flDin),
    .flWeN(flWeN), .flOeN(flOeN), .done(done), .pass(pass), .fail(fail)
  );

  int errors = 0, checks = 0;

  // flash model state
  logic          curErase = 1'b0;
  logic [7:0]    curExp = '0, curFin = '0;
  int            curBusy = 0;
  logic [AW-1:0] curAddr = '0;
  int rdCount = 0, wrCount = 0, badAddr = 0, wrAtFirst = 0;
  int rdBase = 0, wrBase = 0, badBase = 0;
  logic [AW-1:0] wrLogA [8];
  logic [7:0]    wrLogD [8];
  int overlapErr = 0, longOeErr = 0;
  logic prevOeLow = 1'b0;

  function automatic logic [7:0] modelWord(input int k, input logic er,
      input logic [7:0] ex, input int b, input logic [7:0] fn);
    logic [7:0] w;
    if (k < 0)       w = fn;
    else if (k < b)  w = {er ? 1'b0 : ~ex[7], k[0], 6'h2A};
    else if (k == b) w = {fn[7], k[0], 6'h15};
    else             w = fn;
    return w;
  endfunction

  always_comb flDin = modelWord(rdCount - rdBase, curErase, curExp, curBusy, curFin);

  always @(posedge flOeN) begin
    if (rdCount == rdBase) wrAtFirst = wrCount - wrBase;
    if (flAddr !== curAddr) badAddr = badAddr + 1;
    rdCount = rdCount + 1;
  end

  always @(posedge flWeN) begin
    if ((wrCount - wrBase) >= 0 && (wrCount - wrBase) < 8) begin
      wrLogA[wrCount - wrBase] = flAddr;
      wrLogD[wrCount - wrBase] = flDout;
    end
    wrCount = wrCount + 1;
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (!flOeN && !flWeN) overlapErr = overlapErr + 1;
      if (!flOeN && prevOeLow) longOeErr = longOeErr + 1;
      prevOeLow = !flOeN;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // expected outcome straight from R5..R8
  task automatic refRun(input vec_t v, output bit p, output int n, output bit tmo);
    logic [7:0] w, prevw, last;
    bit det;
    int lim1;
    lim1 = (v.lim == 0) ? 1 : int'(v.lim);
    prevw = '0; p = 0; n = 0; tmo = 0;
    for (int k = 0; k < 300; k++) begin
      w = modelWord(k, v.erase, v.exp, int'(v.busy), v.fin);
      det = v.tog ? (k >= 1 && w[6] == prevw[6]) : (w[7] == (v.erase ? 1'b1 : v.exp[7]));
      if (det) begin
        last = modelWord(k + CONF, v.erase, v.exp, int'(v.busy), v.fin);
        p = (last == (v.erase ? 8'hFF : v.exp));
        n = k + 1 + CONF;
        return;
      end
      if (k + 1 >= lim1) begin
        p = 0; n = k + 1; tmo = 1;
        return;
      end
      prevw = w;
    end
  endtask

  function automatic logic [19:0] expWrite(input logic er, input int i,
      input logic [11:0] a, input logic [7:0] d);
    logic [19:0] r;
    case (i)
      0: r = {12'h555, 8'hAA};
      1: r = {12'h2AA, 8'h55};
      2: r = {12'h555, er ? 8'h80 : 8'hA0};
      3: r = er ? {12'h555, 8'hAA} : {a, d};
      4: r = {12'h2AA, 8'h55};
      default: r = {a, 8'h30};
    endcase
    return r;
  endfunction

  task automatic runVec(input vec_t v, input int idx);
    bit pRef, tmo, gotPass, gotFail;
    int nRef, cyc, nWr;
    string modeTag;
    curErase = v.erase; curExp = v.exp; curBusy = int'(v.busy);
    curFin = v.fin; curAddr = v.addr;
    rdBase = rdCount; wrBase = wrCount; badBase = badAddr;
    @(negedge clk);
    reqValid = 1'b1; reqErase = v.erase; reqToggle = v.tog;
    reqAddr = v.addr; reqData = v.exp; timeoutLimit = v.lim;
    @(negedge clk);
    reqValid = 1'b0;
    cyc = 0;
    while (!done && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    gotPass = pass; gotFail = fail;
    refRun(v, pRef, nRef, tmo);
    modeTag = tmo ? "R8" : (v.tog ? "R6" : "R5");
    check(done, "R9 done seen", int'(done), 1);
    check(gotPass == pRef, {modeTag, "/R7 pass"}, int'(gotPass), int'(pRef));
    check(gotFail == !pRef, "R9 fail", int'(gotFail), int'(!pRef));
    @(negedge clk);
    check(!done && !pass && !fail, "R9 strobe width", int'(done), 0);
    check(rdCount - rdBase == nRef, {modeTag, "/R7 read count"}, rdCount - rdBase, nRef);
    nWr = v.erase ? 6 : 4;
    check(wrCount - wrBase == nWr, v.erase ? "R2 write count" : "R1 write count",
          wrCount - wrBase, nWr);
    check(wrAtFirst == nWr, "R3 writes before first read", wrAtFirst, nWr);
    check(badAddr == badBase, "R3 poll address", badAddr - badBase, 0);
    for (int i = 0; i < nWr; i++) begin
      check({wrLogA[i], wrLogD[i]} == expWrite(v.erase, i, v.addr, v.exp),
            v.erase ? "R2 write pair" : "R1 write pair",
            int'({wrLogA[i], wrLogD[i]}), int'(expWrite(v.erase, i, v.addr, v.exp)));
    end
    if (idx < 0) $display("unreachable");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(flWeN && flOeN, "R10 strobes idle in reset", int'({flWeN, flOeN}), 3);
    check(!done && !pass && !fail, "R10 results low in reset", int'({done, pass, fail}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(flWeN && flOeN && !done, "R10 idle after reset", int'({flWeN, flOeN, done}), 6);

    for (int i = 0; i < NV; i++) runVec(VECS[i], i);

    // R4 bus pulse discipline across the whole run
    check(overlapErr == 0, "R4 WE/OE overlap", overlapErr, 0);
    check(longOeErr == 0, "R4 OE pulse width", longOeErr, 0);

    // R9 back-to-back request accepted right after completion
    runVec(VECS[0], 99);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule